// File: doc/BRIEF.md
# Byte-Wide Converter Host Port

This block sits between a byte-wide processor bus and the core of a 12-bit, four-input sampling converter. The host drives active-low chip-select, read and write strobes, a byte-select line and a register-select line, plus a 2-bit channel address. Releasing a write strobe starts a conversion on the addressed channel, or loads the control register. Reads return the result in two bytes or return a status register. The bus is modelled as a data output with a separate drive-enable, and all host inputs are sampled on the block clock.

The control register picks how results are shown. In transparent mode the bus shows the core's live result. In held mode it shows the last result the core reported as complete. The register also requests calibration, enters and leaves power-down, and clears a sticky power-fail flag. A power-fail event from the core sets that flag and returns the control state to its defaults.

Top module: `hbi_host_port`

## Requirements
- R1: The internal read strobe is active only when `cs_ni` and `rd_ni` are both LOW. The internal write strobe is active only when `cs_ni` and `wr_ni` are both LOW. Strobe LOW levels with `cs_ni` HIGH have no effect.
- R2: When the write strobe ends with `sfr_i` LOW, `conv_start_o` pulses for one cycle in the cycle after the first clock edge at which the strobe is seen inactive. In the same cycle `chan_o` takes the `addr_i` value held during the strobe, where 0..3 select channels 0..3.
- R3: In transparent mode, a read with `sfr_i` LOW and `hbe_i` LOW returns `result_i[7:0]`.
- R4: A read with `sfr_i` LOW and `hbe_i` HIGH returns result bits 11..8 on bits 3..0 and zeros on bits 6..4. Bit 7 is HIGH while `conv_busy_i` or `cal_busy_i` is HIGH.
- R5: If `hbe_i` changes while the read strobe is active, the bus follows the new selection in the same cycle.
- R6: A read with `sfr_i` and `hbe_i` both HIGH returns status with these bits: 0 held mode, 1 calibrating, 2 zero, 3 power-down, 4 zero, 5 power-fail, 6 calibration error, 7 busy (converting or calibrating).
- R7: A write with `sfr_i` and `hbe_i` both HIGH sets the control fields as follows. Bit 0 selects held mode (`latched_o`). Bit 3 enters power-down (`pwrdn_o`) and a 0 there leaves it. Bit 1 pulses `cal_start_o` and clears power-down. Bit 5 LOW clears the power-fail flag.
- R8: A control-register write also starts a conversion, under the same rules as R2.
- R9: With no read strobe active, `data_oe_o` is LOW and `data_o` is zero.
- R10: A read with `sfr_i` HIGH and `hbe_i` LOW returns zero. A write with that selection changes nothing and starts nothing. Control bits 2, 4, 6 and 7 are ignored.
- R11: A conversion request made while `conv_busy_i` or `cal_busy_i` is HIGH is dropped, and `chan_o` keeps its value.
- R12: In held mode, result reads show the `result_i` value captured on the last cycle with `conv_done_i` HIGH, whatever `result_i` does afterwards.
- R13: A cycle with `pwr_fail_i` HIGH sets the power-fail flag, returns to transparent mode and leaves power-down. It takes priority over a write ending in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active LOW |
| cs_ni | input | 1 | Chip select, active LOW |
| rd_ni | input | 1 | Read strobe, active LOW |
| wr_ni | input | 1 | Write strobe, active LOW |
| hbe_i | input | 1 | High byte / status select |
| sfr_i | input | 1 | Register select |
| addr_i | input | 2 | Channel address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Bus drive enable |
| result_i | input | 12 | Result from converter core |
| conv_done_i | input | 1 | Conversion complete pulse |
| conv_busy_i | input | 1 | Conversion in progress |
| cal_busy_i | input | 1 | Calibration in progress |
| cal_err_i | input | 1 | Calibration overflow flag |
| pwr_fail_i | input | 1 | Supply-failure event |
| conv_start_o | output | 1 | Conversion start pulse |
| chan_o | output | 2 | Latched channel |
| cal_start_o | output | 1 | Calibration start pulse |
| latched_o | output | 1 | Held result mode |
| pwrdn_o | output | 1 | Power-down mode |

## Verification
The assertions assume that every host input is steady around each clock edge. They also assume that reset is released before any strobe is active, and that busy and done come from a core that follows the start pulses. The stimulus changes inputs only at falling clock edges and raises busy only as a level set by the bench. Random phases mix strobes, selects and core flags freely, and ordered phases walk through dropped requests, held mode, power-fail priority and the reserved selection.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  parameter int unsigned CH_W   = 2;
  parameter int unsigned BYTE_W = 8;
  parameter int unsigned RES_W  = 12;

  // control / status bit positions (host software decodes these)
  localparam int unsigned B_MODE  = 0;
  localparam int unsigned B_CAL   = 1;
  localparam int unsigned B_PD    = 3;
  localparam int unsigned B_PFAIL = 5;
  localparam int unsigned B_CERR  = 6;
  localparam int unsigned B_BUSY  = 7;

  typedef struct packed {
    logic              sfr;
    logic              hbe;
    logic [CH_W-1:0]   addr;
    logic [BYTE_W-1:0] data;
  } wr_hold_t;
endpackage

// File: rtl/hbi_wr_capture.sv
module hbi_wr_capture
  import hbi_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_act_i,
  input  wr_hold_t        fields_i,
  output wr_hold_t        hold_o,
  output logic            wr_end_o
);
  logic act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      hold_o <= '0;
    end else begin
      act_q <= wr_act_i;
      if (wr_act_i) hold_o <= fields_i;
    end
  end

  // strobe release = host rising edge
  assign wr_end_o = act_q & ~wr_act_i;
endmodule

// File: rtl/hbi_ctrl_regs.sv
module hbi_ctrl_regs
  import hbi_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_end_i,
  input  wr_hold_t        hold_i,
  input  logic            busy_i,
  input  logic            pwr_fail_i,
  output logic            mode_o,
  output logic            pd_o,
  output logic            pfail_o,
  output logic            conv_start_o,
  output logic            cal_start_o,
  output logic [CH_W-1:0] chan_o
);
  logic ctrl_wr, conv_req;

  assign ctrl_wr  = wr_end_i & hold_i.sfr & hold_i.hbe;
  assign conv_req = wr_end_i & (~hold_i.sfr | hold_i.hbe);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o       <= 1'b0;
      pd_o         <= 1'b0;
      pfail_o      <= 1'b0;
      conv_start_o <= 1'b0;
      cal_start_o  <= 1'b0;
      chan_o       <= '0;
    end else begin
      conv_start_o <= 1'b0;
      cal_start_o  <= 1'b0;
      if (pwr_fail_i) begin
        pfail_o <= 1'b1;
        mode_o  <= 1'b0;
        pd_o    <= 1'b0;
      end else begin
        if (ctrl_wr) begin
          mode_o      <= hold_i.data[B_MODE];
          pd_o        <= hold_i.data[B_PD] & ~hold_i.data[B_CAL];
          cal_start_o <= hold_i.data[B_CAL];
          if (!hold_i.data[B_PFAIL]) pfail_o <= 1'b0;
        end
        if (conv_req && !busy_i) begin
          conv_start_o <= 1'b1;
          chan_o       <= hold_i.addr;
        end
      end
    end
  end

  assert_no_start_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !$past(busy_i));
  assert_chan_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_start_o |-> $stable(chan_o));
  assert_pfail_set_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwr_fail_i) |-> (pfail_o && !mode_o && !pd_o));
  assert_cal_wakes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> !pd_o);
endmodule

// File: rtl/hbi_rd_mux.sv
module hbi_rd_mux
  import hbi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_act_i,
  input  logic              sfr_i,
  input  logic              hbe_i,
  input  logic              mode_i,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  result_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int unsigned HI_W  = RES_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - 1 - HI_W;

  logic [RES_W-1:0]  res_q, res_sel;
  logic [BYTE_W-1:0] hi_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          res_q <= '0;
    else if (conv_done_i) res_q <= result_i;
  end

  assign res_sel = mode_i ? res_q : result_i;
  assign hi_byte = {busy_i, {PAD_W{1'b0}}, res_sel[RES_W-1:BYTE_W]};

  always_comb begin
    data_o = '0;
    if (rd_act_i) begin
      unique case ({sfr_i, hbe_i})
        2'b00:   data_o = res_sel[BYTE_W-1:0];
        2'b01:   data_o = hi_byte;
        2'b11:   data_o = status_i;
        default: data_o = '0;
      endcase
    end
  end

  assign data_oe_o = rd_act_i;
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port
  import hbi_pkg::*;
#(
  parameter int unsigned P_CH_W   = CH_W,
  parameter int unsigned P_BYTE_W = BYTE_W,
  parameter int unsigned P_RES_W  = RES_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                rd_ni,
  input  logic                wr_ni,
  input  logic                hbe_i,
  input  logic                sfr_i,
  input  logic [P_CH_W-1:0]   addr_i,
  input  logic [P_BYTE_W-1:0] data_i,
  output logic [P_BYTE_W-1:0] data_o,
  output logic                data_oe_o,
  input  logic [P_RES_W-1:0]  result_i,
  input  logic                conv_done_i,
  input  logic                conv_busy_i,
  input  logic                cal_busy_i,
  input  logic                cal_err_i,
  input  logic                pwr_fail_i,
  output logic                conv_start_o,
  output logic [P_CH_W-1:0]   chan_o,
  output logic                cal_start_o,
  output logic                latched_o,
  output logic                pwrdn_o
);
  logic              rd_act, wr_act, wr_end, busy, pfail;
  wr_hold_t          fields, hold;
  logic [BYTE_W-1:0] status;

  assign rd_act = ~(cs_ni | rd_ni);
  assign wr_act = ~(cs_ni | wr_ni);
  assign busy   = conv_busy_i | cal_busy_i;
  assign fields = '{sfr: sfr_i, hbe: hbe_i, addr: addr_i, data: data_i};

  always_comb begin
    status          = '0;
    status[B_MODE]  = latched_o;
    status[B_CAL]   = cal_busy_i;
    status[B_PD]    = pwrdn_o;
    status[B_PFAIL] = pfail;
    status[B_CERR]  = cal_err_i;
    status[B_BUSY]  = busy;
  end

  hbi_wr_capture u_wr (
    .clk_i, .rst_ni, .wr_act_i(wr_act), .fields_i(fields),
    .hold_o(hold), .wr_end_o(wr_end)
  );

  hbi_ctrl_regs u_ctrl (
    .clk_i, .rst_ni, .wr_end_i(wr_end), .hold_i(hold), .busy_i(busy),
    .pwr_fail_i, .mode_o(latched_o), .pd_o(pwrdn_o), .pfail_o(pfail),
    .conv_start_o, .cal_start_o, .chan_o
  );

  hbi_rd_mux u_rd (
    .clk_i, .rst_ni, .rd_act_i(rd_act), .sfr_i, .hbe_i, .mode_i(latched_o),
    .conv_done_i, .result_i, .busy_i(busy), .status_i(status),
    .data_o, .data_oe_o
  );

  assert_bus_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || rd_ni) |-> (!data_oe_o && data_o == '0));
endmodule

// File: tb/hbi_host_port_tb.sv
module hbi_host_port_tb;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, hbe = 0, sfr = 0;
  logic [1:0] addr = 0;
  logic [7:0] din = 0, dout;
  logic [11:0] res = 0;
  logic oe, done = 0, cbusy = 0, kbusy = 0, cerr = 0, pfi = 0;
  logic cstart, kstart, latched, pd;
  logic [1:0] chan;
  int checks = 0, errors = 0;

  always #4ns clk = ~clk;

  hbi_host_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .hbe_i(hbe), .sfr_i(sfr), .addr_i(addr), .data_i(din), .data_o(dout),
    .data_oe_o(oe), .result_i(res), .conv_done_i(done), .conv_busy_i(cbusy),
    .cal_busy_i(kbusy), .cal_err_i(cerr), .pwr_fail_i(pfi),
    .conv_start_o(cstart), .chan_o(chan), .cal_start_o(kstart),
    .latched_o(latched), .pwrdn_o(pd)
  );

  // behavioural reference
  bit m_mode, m_pd, m_pf, m_cs, m_ks, m_prev;
  bit [1:0] m_chan;
  bit [11:0] m_res;
  bit h_sfr, h_hbe;
  bit [1:0] h_addr;
  bit [7:0] h_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pd = 0; m_pf = 0; m_cs = 0; m_ks = 0; m_prev = 0;
      m_chan = 0; m_res = 0; h_sfr = 0; h_hbe = 0; h_addr = 0; h_data = 0;
    end else begin
      bit act, fin;
      act = !cs_n && !wr_n;           // R1
      fin = m_prev && !act;
      m_cs = 0; m_ks = 0;
      if (pfi) begin
        m_pf = 1; m_mode = 0; m_pd = 0;
      end else if (fin) begin
        if (h_sfr && h_hbe) begin
          m_mode = h_data[0];
          m_pd = h_data[3] && !h_data[1];
          m_ks = h_data[1];
          if (!h_data[5]) m_pf = 0;
        end
        if ((!h_sfr || h_hbe) && !(cbusy || kbusy)) begin
          m_cs = 1; m_chan = h_addr;
        end
      end
      if (done) m_res = res;
      if (act) begin h_sfr = sfr; h_hbe = hbe; h_addr = addr; h_data = din; end
      m_prev = act;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit rd, b;
    bit [11:0] r;
    bit [7:0] e;
    string tag;
    rd = !cs_n && !rd_n;
    b = cbusy || kbusy;
    r = m_mode ? m_res : res;
    e = 0;
    if (!rd) tag = "R9";
    else if (sfr && !hbe) tag = "R10";
    else if (sfr) begin
      tag = "R6";
      e = {b, cerr, m_pf, 1'b0, m_pd, 1'b0, kbusy, m_mode};
    end else if (hbe) begin tag = "R4"; e = {b, 3'b0, r[11:8]}; end
    else begin tag = m_mode ? "R12" : "R3"; e = r[7:0]; end
    chk({tag, " data"}, int'(dout), int'(e));
    chk("R9 oe", int'(oe), int'(rd));
    chk("R2 conv_start", int'(cstart), int'(m_cs));
    chk("R11 chan", int'(chan), int'(m_chan));
    chk("R7 cal_start", int'(kstart), int'(m_ks));
    chk("R7 latched", int'(latched), int'(m_mode));
    chk("R13 pwrdn", int'(pd), int'(m_pd));
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) compare();
    end
  endtask

  task automatic bus_wr(bit s, bit h, bit [1:0] a, bit [7:0] d);
    sfr = s; hbe = h; addr = a; din = d; cs_n = 0; wr_n = 0;
    tick(2);
    wr_n = 1; cs_n = 1; din = 8'h5A; addr = ~a;   // later values must not leak
    tick(2);
  endtask

  task automatic bus_rd(bit s, bit h);
    sfr = s; hbe = h; cs_n = 0; rd_n = 0;
    tick(1);
    hbe = !h;                                      // R5 select follows
    tick(1);
    hbe = h;
    tick(1);
    rd_n = 1; cs_n = 1;
    tick(1);
  endtask

  initial begin
    #(8ns * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);                                       // reset state
    res = 12'hA5C;
    bus_rd(0, 0); bus_rd(0, 1);                    // R3 R4
    bus_wr(0, 0, 2'd2, 8'h00);                     // R2 channel 2
    cbusy = 1; bus_rd(0, 1);                       // R4 busy flag
    bus_wr(0, 0, 2'd3, 8'h00);                     // R11 dropped
    cbusy = 0;
    cs_n = 1; wr_n = 0; addr = 1; tick(3); wr_n = 1; tick(2); // R1
    cs_n = 1; rd_n = 0; tick(2); rd_n = 1;         // R1 R9
    bus_wr(1, 1, 2'd1, 8'h01);                     // R7 held mode, R8 start
    res = 12'h3C7; done = 1; tick(1); done = 0;
    res = 12'hFFF; bus_rd(0, 0); bus_rd(0, 1);     // R12
    bus_wr(1, 1, 2'd0, 8'h08);                     // R7 power-down
    bus_rd(1, 1);
    kbusy = 1; bus_wr(1, 1, 2'd2, 8'h0A);          // R7 cal clears pd, R11
    cerr = 1; bus_rd(1, 1); kbusy = 0; cerr = 0;   // R6
    pfi = 1; tick(1); pfi = 0; tick(1);            // R13
    bus_rd(1, 1);
    bus_wr(1, 1, 2'd1, 8'h20); bus_rd(1, 1);       // pfail kept
    bus_wr(1, 1, 2'd3, 8'h54); bus_rd(1, 1);       // R10 reserved bits, clears pfail
    bus_wr(1, 0, 2'd2, 8'h09); bus_rd(1, 0);       // R10 ignored selection
    bus_wr(1, 1, 2'd0, 8'h01);
    sfr = 1; hbe = 1; din = 8'h00; cs_n = 0; wr_n = 0; tick(1);
    wr_n = 1; cs_n = 1; pfi = 1; tick(1); pfi = 0; tick(2); // R13 priority
    for (int i = 0; i < 600; i++) begin
      bit [31:0] v;
      v = $urandom;
      cs_n = v[0] & v[1]; rd_n = v[2]; wr_n = v[3];
      sfr = v[4] & v[5]; hbe = v[6]; addr = v[8:7]; din = v[16:9];
      cbusy = v[17] & v[18]; kbusy = v[19] & v[20] & v[21];
      cerr = v[22] & v[23]; pfi = (v[31:26] == 0); done = v[24] & v[25];
      res = $urandom;
      tick(1);
    end
    cs_n = 1; rd_n = 1; wr_n = 1; pfi = 0; done = 0;
    tick(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule